// File: doc/BRIEF.md
# Triggered Stream Snapshot Generator

This block delivers a single synthetic picture over an AXI4-Stream master port each time a capture request is seen. It behaves like a still camera, not a continuous video source. Every pixel is one 32-bit word taken from a counter that starts at zero for each picture and steps by one for each accepted beat. The first pixel of the picture carries a start flag on TUSER bit 0, and the final pixel of each line carries TLAST.

The width and height of the picture and the pixel cadence are parameters. The cadence is the spacing between pixel offers, counted in clocks. Outputs change only when a beat completes, so a slow sink can stall the stream at any point without losing or repeating pixels. A busy flag covers the whole picture, and a one-cycle done pulse marks its end.

Top module: `snap_frame_gen`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is held, and immediately after it, m_tvalid, busy and done are all 0.
- R2: A cap_req sampled high while idle starts a picture. In the next cycle busy and m_tvalid are 1, and the first pixel is on m_tdata.
- R3: m_tdata is 0 on the first pixel of every picture and grows by exactly 1 with each accepted beat (m_tvalid and m_tready both high).
- R4: m_tuser is 1 on the first pixel of the picture only, and 0 on every other beat.
- R5: A picture has exactly COLS*ROWS accepted beats. m_tlast is 1 on beat numbers COLS-1, 2*COLS-1 and so on (counting from 0), the final beat included, and 0 on every other beat.
- R6: m_tkeep is all ones on every beat.
- R7: While m_tvalid is 1 and m_tready is 0, m_tvalid stays 1 and m_tdata, m_tlast and m_tuser hold their values into the next cycle.
- R8: If PACE is greater than 1, m_tvalid drops for the cycle after every accepted beat that is not the final one. With m_tready held high, accepted beats come exactly PACE cycles apart.
- R9: The cycle after the final beat is accepted, done is 1 for one cycle, busy is 0, and m_tvalid stays 0 until the next request.
- R10: A cap_req raised while busy has no effect. The current picture neither restarts nor grows, and no second picture follows it.
- R11: m_tvalid rises even while m_tready is held low. The offer does not wait for the sink to be ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_req | input | 1 | Capture request, sampled while idle |
| m_tready | input | 1 | Sink ready |
| m_tdata | output | DW | Pixel value |
| m_tvalid | output | 1 | Pixel offered |
| m_tlast | output | 1 | Last pixel of a line |
| m_tuser | output | 1 | Start of picture (bit 0) |
| m_tkeep | output | DW/8 | Byte keep, always all ones |
| busy | output | 1 | A picture is in progress |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The assertions assume that m_tready is a clean level held constant within each cycle and that cap_req is synchronous to clk. The handshake checks place no other requirement on m_tready, because any pattern the sink drives is legal. The stimulus changes m_tready and cap_req only on falling edges. It drives m_tready in three ways: held high, a pseudo-random stall pattern, and held low before the first offer. It raises a request in the middle of a picture to exercise the ignore rule.

// File: rtl/snap_frame_gen.sv
module snap_frame_gen #(
  parameter int COLS = 10,
  parameter int ROWS = 10,
  parameter int DW   = 32,
  parameter int PACE = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_req,
  input  logic            m_tready,
  output logic [DW-1:0]   m_tdata,
  output logic            m_tvalid,
  output logic            m_tlast,
  output logic            m_tuser,
  output logic [DW/8-1:0] m_tkeep,
  output logic            busy,
  output logic            done
);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int GW = $clog2(PACE + 1);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [DW-1:0] pix;
  logic [GW-1:0] gap;
  logic          vld, bsy, dn;

  wire hs  = vld & m_tready;
  wire eol = (col == CW'(COLS - 1));
  wire eof = eol & (row == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0; row <= '0; pix <= '0; gap <= '0;
      vld <= 1'b0; bsy <= 1'b0; dn <= 1'b0;
    end else begin
      dn <= 1'b0;
      if (!bsy) begin
        if (cap_req) begin
          bsy <= 1'b1; vld <= 1'b1;
          col <= '0; row <= '0; pix <= '0; gap <= '0;
        end
      end else if (hs) begin
        pix <= pix + 1'b1;
        if (eof) begin
          bsy <= 1'b0; vld <= 1'b0; dn <= 1'b1;
        end else begin
          if (eol) begin
            col <= '0;
            row <= row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
          if (PACE == 1) begin
            vld <= 1'b1;
          end else begin
            vld <= 1'b0;
            gap <= GW'(PACE - 1);
          end
        end
      end else if (!vld) begin
        gap <= gap - 1'b1;
        if (gap == GW'(1)) vld <= 1'b1;
      end
    end
  end

  assign m_tdata  = pix;
  assign m_tvalid = vld;
  assign m_tuser  = vld & (col == '0) & (row == '0);
  assign m_tlast  = vld & eol;
  assign m_tkeep  = '1;
  assign busy     = bsy;
  assign done     = dn;

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cap_req) |=> (busy && m_tvalid && m_tuser));
  a_r4_user_first: assert property (@(posedge clk) disable iff (!rst_n)
    m_tuser |-> (m_tdata == '0));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser)));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !m_tlast) |=> (m_tdata == $past(m_tdata) + 1'b1));
  a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (PACE > 1 && m_tvalid && m_tready && !done && busy && !(m_tlast && m_tdata == DW'(COLS*ROWS-1))) |=> !m_tvalid);
  a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !m_tvalid));
  a_r9_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r11_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> busy);
endmodule

// File: tb/sim_snap_frame_gen.sv
module sim_snap_frame_gen;
  localparam int COLS = 10, ROWS = 10, DW = 32, PACE = 24;
  localparam int NPIX = COLS * ROWS;

  logic clk = 0, rst_n = 0, cap_req = 0, m_tready = 1;
  logic [DW-1:0] m_tdata;
  logic m_tvalid, m_tlast, m_tuser, busy, done;
  logic [DW/8-1:0] m_tkeep;

  snap_frame_gen #(.COLS(COLS), .ROWS(ROWS), .DW(DW), .PACE(PACE)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tuser(m_tuser),
    .m_tkeep(m_tkeep), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  typedef struct packed { logic [DW-1:0] d; logic l; logic u; } beat_t;
  beat_t expq[$];
  int checks = 0, fails = 0, cyc = 0, mode = 0, accepted = 0, last_cyc = 0;
  bit have_prev = 0, prev_stall = 0, finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  beat_t prev;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial forever @(posedge clk) cyc++;

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    case (mode)
      0: m_tready = 1'b1;
      1: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = lfsr[0] | lfsr[3];
      end
      default: m_tready = 1'b0;
    endcase
    if (rst_n && m_tvalid) begin
      chk(m_tkeep == '1, "R6", "tkeep", m_tkeep, 15);
      if (prev_stall) begin
        chk(m_tdata == prev.d, "R7", "held tdata", m_tdata, prev.d);
        chk(m_tlast == prev.l && m_tuser == prev.u, "R7", "held flags",
            {m_tlast, m_tuser}, {prev.l, prev.u});
      end
    end
    if (rst_n && prev_stall) chk(m_tvalid, "R7", "valid held", m_tvalid, 1);
    if (rst_n && m_tvalid && m_tready) begin
      beat_t e;
      if (expq.size() == 0) begin
        chk(0, "R10", "unexpected beat", m_tdata, -1);
      end else begin
        e = expq.pop_front();
        chk(m_tdata == e.d, "R3", "tdata", m_tdata, e.d);
        chk(m_tlast == e.l, "R5", "tlast", m_tlast, e.l);
        chk(m_tuser == e.u, "R4", "tuser", m_tuser, e.u);
        if (mode == 0 && have_prev)
          chk(cyc - last_cyc == PACE, "R8", "beat spacing", cyc - last_cyc, PACE);
        last_cyc = cyc;
        have_prev = !e.l || (e.d != DW'(NPIX - 1));
      end
      accepted++;
    end
    prev_stall = rst_n && m_tvalid && !m_tready;
    prev = '{d: m_tdata, l: m_tlast, u: m_tuser};
  end

  task automatic push_frame();
    for (int j = 0; j < NPIX; j++)
      expq.push_back('{d: DW'(j), l: (j % COLS == COLS - 1), u: (j == 0)});
    accepted = 0;
    have_prev = 0;
  endtask

  task automatic request();
    @(negedge clk); cap_req = 1;
    @(negedge clk); cap_req = 0;
    chk(busy && m_tvalid, "R2", "busy&valid after request", {busy, m_tvalid}, 3);
  endtask

  task automatic finish_frame(input bit poke);
    int n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (poke && n == 300) cap_req = 1;
      if (poke && n == 301) cap_req = 0;
    end
    chk(!busy, "R9", "busy at done", busy, 0);
    chk(expq.size() == 0 && accepted == NPIX, "R5", "beats per picture", accepted, NPIX);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", done, 0);
    for (int k = 0; k < 2 * PACE; k++) begin
      @(negedge clk);
      if (m_tvalid || busy) begin
        chk(0, poke ? "R10" : "R9", "idle after picture", m_tvalid, 0);
        break;
      end
    end
    chk(!m_tvalid && !busy, poke ? "R10" : "R9", "still idle", m_tvalid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!m_tvalid && !busy && !done, "R1", "reset outputs", {m_tvalid, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!m_tvalid && !busy, "R1", "idle after reset", {m_tvalid, busy}, 0);

    mode = 0; push_frame(); request(); finish_frame(0);
    mode = 1; push_frame(); request(); finish_frame(0);

    mode = 2; push_frame(); request();
    repeat (5) @(negedge clk);
    chk(m_tvalid && m_tuser && m_tdata == 0, "R11", "offer without ready",
        {m_tvalid, m_tuser}, 3);
    mode = 0; finish_frame(0);

    mode = 0; push_frame(); request(); finish_frame(1);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end
endmodule